// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This unit permutes the bits of a 64-bit operand. Each source bit at index i moves to index i XOR k, where k is a control amount. One pass through a six-stage butterfly network can swap single bits, bit pairs, nibbles, bytes, halfwords or words, in any combination. A control amount of all ones reverses the whole operand.

The control amount comes from one of two inputs, chosen by a select flag. One is a full register value. The other is a short immediate. Either value is reduced modulo the active width.

A word-mode flag limits the operation to the low 32 bits. In that mode the upper half of the result is zero.

Every result also gets a 4-bit condition field. It classifies the 64-bit result, read as a signed number, against zero. The result and the condition are registered, so both appear one cycle after a valid request.

Top module: `grev_unit`

## Requirements
- R1: The amount k is the selected control value modulo the active width. The active width is 64 normally and 32 when `word_mode` is 1, so k has 6 bits or 5 bits.
- R2: For every i below the active width, result bit i XOR k equals source bit i.
- R3: When `word_mode` is 1, only source bits 31:0 affect the result, and result bits 63:32 are zero.
- R4: When `use_imm` is 1 the amount comes from `amt_imm_i`, and when it is 0 it comes from `amt_reg_i`. Both forms give identical results for the same reduced amount.
- R5: `cond_o` bit 3 is set when the result is negative, bit 2 when it is positive, and bit 1 when it is zero. Bit 0 is always 0, and exactly one of bits 3:1 is set.
- R6: An amount of 0 passes the source through unchanged, masked to 32 bits in word mode. An amount of all ones reverses the bit order of the active width.
- R7: `out_valid` equals `in_valid` one clock earlier. Reset clears `out_valid`, `result_o` and `cond_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| word_mode | input | 1 | 1 selects the 32-bit active width |
| use_imm | input | 1 | 1 takes the amount from the immediate input |
| src_i | input | 64 | Source operand |
| amt_reg_i | input | 64 | Register-form control amount |
| amt_imm_i | input | 6 | Immediate-form control amount |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Permuted result |
| cond_o | output | 4 | Condition field {lt, gt, eq, 0} |

## Verification
Word-mode masking and condition generation act on the same result in the same cycle. A word-mode request can carry a register amount with bit 5 set and a source whose upper half is all ones. The amount must then drop to 5 bits. The condition must come from a result whose upper half is zero, so it can never report negative. Random requests with the mode flag, the amount source and the amount bits all drawn together provoke this overlap. Each output is compared with a bench model that moves bits one at a time by XOR index and classifies the signed value separately.

// File: rtl/grev_pkg.sv
package grev_pkg;

  // Condition field layout: lt at bit 3, gt at bit 2, eq at bit 1, spare at bit 0.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic spare;
  } grev_cond_t;

  localparam int unsigned COND_W = $bits(grev_cond_t);

endpackage

// File: rtl/grev_operand.sv
module grev_operand #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned AMT_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      word_mode,
  input  logic                      use_imm,
  input  logic [DATA_W-1:0]         src_i,
  input  logic [AMT_W-1:0]          amt_reg_i,
  input  logic [$clog2(DATA_W)-1:0] amt_imm_i,
  output logic [DATA_W-1:0]         src_eff_o,
  output logic [$clog2(DATA_W)-1:0] k_o
);
  localparam int unsigned K_W  = $clog2(DATA_W);
  localparam int unsigned WK_W = $clog2(WORD_W);

  // Full register value reduced modulo the full width.
  function automatic logic [K_W-1:0] reg_to_amt(input logic [AMT_W-1:0] a);
    return K_W'(a % AMT_W'(DATA_W));
  endfunction

  // Further reduction modulo the word width when word mode is active.
  function automatic logic [K_W-1:0] reduce_amt(input logic [K_W-1:0] raw,
                                                input logic wm);
    logic [K_W-1:0] keep;
    keep = K_W'(WORD_W - 1);
    return wm ? (raw & keep) : raw;
  endfunction

  function automatic logic [DATA_W-1:0] mask_src(input logic [DATA_W-1:0] s,
                                                 input logic wm);
    logic [DATA_W-1:0] m;
    m = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    return wm ? (s & m) : s;
  endfunction

  logic [K_W-1:0] raw_amt;

  assign raw_amt   = use_imm ? amt_imm_i : reg_to_amt(amt_reg_i);
  assign k_o       = reduce_amt(raw_amt, word_mode);
  assign src_eff_o = mask_src(src_i, word_mode);

  // R1: in word mode the amount never reaches beyond the word width
  a_r1_word_amount_short: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> (k_o >> WK_W) == '0);

  // R3: masked operand carries no upper bits in word mode
  a_r3_operand_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> (src_eff_o >> WORD_W) == '0);

endmodule

// File: rtl/grev_stage.sv
module grev_stage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAGE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int unsigned GRP = 1 << STAGE;

  logic [DATA_W-1:0] swapped;

  // Exchange neighbouring groups of GRP bits.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign swapped[b] = d_i[b ^ GRP];
  end

  assign q_o = en_i ? swapped : d_i;

  // R2: a permutation stage neither creates nor loses set bits
  a_r2_stage_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_o) == $countones(d_i));

endmodule

// File: rtl/grev_network.sv
module grev_network #(
  parameter int unsigned DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         d_i,
  input  logic [$clog2(DATA_W)-1:0] k_i,
  output logic [DATA_W-1:0]         q_o
);
  localparam int unsigned K_W = $clog2(DATA_W);

  logic [DATA_W-1:0] lvl [0:K_W];

  assign lvl[0] = d_i;

  // Stage j swaps 2^j-bit groups when bit j of the amount is set.
  for (genvar j = 0; j < K_W; j++) begin : g_stage
    grev_stage #(
      .DATA_W (DATA_W),
      .STAGE  (j)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lvl[j]),
      .en_i  (k_i[j]),
      .q_o   (lvl[j+1])
    );
  end

  assign q_o = lvl[K_W];

  // R6: a zero amount leaves the operand untouched through every stage
  a_r6_zero_amount_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (k_i == '0) |-> (q_o == d_i));

endmodule

// File: rtl/grev_cond.sv
module grev_cond #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]      value_i,
  output grev_pkg::grev_cond_t   cond_o
);
  function automatic grev_pkg::grev_cond_t classify(input logic [DATA_W-1:0] v);
    grev_pkg::grev_cond_t c;
    c.lt    = v[DATA_W-1];
    c.eq    = (v == '0);
    c.gt    = !v[DATA_W-1] && (v != '0);
    c.spare = 1'b0;
    return c;
  endfunction

  assign cond_o = classify(value_i);

endmodule

// File: rtl/grev_unit.sv
module grev_unit #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned AMT_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      word_mode,
  input  logic                      use_imm,
  input  logic [DATA_W-1:0]         src_i,
  input  logic [AMT_W-1:0]          amt_reg_i,
  input  logic [$clog2(DATA_W)-1:0] amt_imm_i,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         result_o,
  output logic [3:0]                cond_o
);
  localparam int unsigned K_W = $clog2(DATA_W);

  // Internal events brought out for the checks.
  logic [DATA_W-1:0]    src_eff;
  logic [K_W-1:0]       k_amt;
  logic [DATA_W-1:0]    perm;
  grev_pkg::grev_cond_t cond_next;

  logic                 valid_q;
  logic                 wm_q;
  logic [DATA_W-1:0]    result_q;
  grev_pkg::grev_cond_t cond_q;

  grev_operand #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .AMT_W  (AMT_W)
  ) u_operand (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_mode (word_mode),
    .use_imm   (use_imm),
    .src_i     (src_i),
    .amt_reg_i (amt_reg_i),
    .amt_imm_i (amt_imm_i),
    .src_eff_o (src_eff),
    .k_o       (k_amt)
  );

  grev_network #(
    .DATA_W (DATA_W)
  ) u_network (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_eff),
    .k_i   (k_amt),
    .q_o   (perm)
  );

  grev_cond #(
    .DATA_W (DATA_W)
  ) u_cond (
    .value_i (perm),
    .cond_o  (cond_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      wm_q     <= 1'b0;
      result_q <= '0;
      cond_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        wm_q     <= word_mode;
        result_q <= perm;
        cond_q   <= cond_next;
      end
    end
  end

  assign out_valid = valid_q;
  assign result_o  = result_q;
  assign cond_o    = cond_q;

  // R7: valid output tracks the request one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: word-mode results carry nothing above the word
  a_r3_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && wm_q) |-> (result_q >> WORD_W) == '0);

  // R5: exactly one relation flag, spare bit low
  a_r5_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($countones(cond_q[3:1]) == 1 && !cond_q[0]));

  // R5: the negative flag agrees with the registered sign bit
  a_r5_lt_matches_sign: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (cond_q[3] == result_q[DATA_W-1]));

  // R6: a zero amount yields the masked operand one cycle later
  a_r6_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && k_amt == '0) |=> (result_q == $past(src_eff)));

endmodule

// File: tb/grev_unit_test.sv
`timescale 1ns/1ps
module grev_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        word_mode = 1'b0;
  logic        use_imm = 1'b0;
  logic [63:0] src_i = '0;
  logic [63:0] amt_reg_i = '0;
  logic [5:0]  amt_imm_i = '0;
  logic        out_valid;
  logic [63:0] result_o;
  logic [3:0]  cond_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  grev_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .word_mode (word_mode),
    .use_imm   (use_imm),
    .src_i     (src_i),
    .amt_reg_i (amt_reg_i),
    .amt_imm_i (amt_imm_i),
    .out_valid (out_valid),
    .result_o  (result_o),
    .cond_o    (cond_o)
  );

  // Bench model: move bits one at a time to their XOR index.
  function automatic logic [63:0] model_perm(input logic [63:0] s, input int unsigned k,
                                             input bit wm);
    logic [63:0] r;
    int unsigned width;
    width = wm ? 32 : 64;
    r = '0;
    for (int unsigned i = 0; i < width; i++) r[i ^ (k % width)] = s[i];
    return r;
  endfunction

  function automatic logic [3:0] model_cond(input logic [63:0] v);
    longint signed sv;
    sv = signed'(v);
    if (sv < 0) return 4'b1000;
    if (sv > 0) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply one request, return the registered outputs one cycle later.
  task automatic apply(input logic [63:0] s, input logic [63:0] ra, input logic [5:0] im,
                       input bit ui, input bit wm,
                       output logic [63:0] res, output logic [3:0] cc);
    @(negedge clk);
    src_i = s; amt_reg_i = ra; amt_imm_i = im; use_imm = ui; word_mode = wm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R7", "out_valid", {63'd0, out_valid}, 64'd1);
    res = result_o;
    cc = cond_o;
  endtask

  task automatic run_checked(input string req, input logic [63:0] s, input logic [63:0] ra,
                             input logic [5:0] im, input bit ui, input bit wm);
    logic [63:0] res;
    logic [3:0] cc;
    logic [63:0] exp;
    int unsigned k;
    k = ui ? int'(im) : int'(ra % 64);
    exp = model_perm(s, k, wm);
    apply(s, ra, im, ui, wm, res, cc);
    check64(req, "result", res, exp);
    check64("R5", "cond", {60'd0, cc}, {60'd0, model_cond(exp)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r1, r2, rev;
    logic [3:0] c1, c2;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    // R7: reset state
    check64("R7", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check64("R7", "reset result", result_o, 64'd0);
    check64("R7", "reset cond", {60'd0, cond_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: zero amount passes through, masked in word mode
    apply(64'hDEAD_BEEF_0123_4567, 64'd0, 6'd0, 1'b0, 1'b0, r1, c1);
    check64("R6", "zero amount", r1, 64'hDEAD_BEEF_0123_4567);
    apply(64'hDEAD_BEEF_0123_4567, 64'd0, 6'd0, 1'b1, 1'b1, r1, c1);
    check64("R6", "zero amount word", r1, 64'h0000_0000_0123_4567);

    // R6: all ones reverses the active width
    rev = {<<{64'hF000_0000_0000_00A5}};
    apply(64'hF000_0000_0000_00A5, 64'd0, 6'd63, 1'b1, 1'b0, r1, c1);
    check64("R6", "full reverse", r1, rev);
    apply(64'hFFFF_FFFF_8000_0001, 64'd31, 6'd0, 1'b0, 1'b1, r1, c1);
    check64("R6", "word reverse", r1, 64'h0000_0000_8000_0001);

    // R1: register amount reduced modulo width (0x7F -> 63, word -> 31)
    run_checked("R1", 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_007F, 6'd0, 1'b0, 1'b0);
    run_checked("R1", 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 1'b0, 1'b1);
    // R3: upper source bits ignored in word mode, result upper half zero
    apply(64'hFFFF_FFFF_0000_0000, 64'd6, 6'd0, 1'b0, 1'b1, r1, c1);
    check64("R3", "word upper ignored", r1, 64'd0);
    check64("R5", "word zero eq", {60'd0, c1}, 64'd2);
    apply(64'h1234_5678_0000_0000, 64'd6, 6'd0, 1'b0, 1'b1, r2, c2);
    check64("R3", "word upper source no effect", r2, r1);

    // R4: immediate and register forms agree
    apply(64'hA5A5_0F0F_3C3C_9999, 64'd0, 6'd21, 1'b1, 1'b0, r1, c1);
    apply(64'hA5A5_0F0F_3C3C_9999, 64'd21 + 64'd128, 6'd0, 1'b0, 1'b0, r2, c2);
    check64("R4", "imm vs reg", r1, r2);
    check64("R4", "imm vs reg model", r1, model_perm(64'hA5A5_0F0F_3C3C_9999, 21, 1'b0));
    apply(64'hA5A5_0F0F_3C3C_9999, 64'd0, 6'd21, 1'b0, 1'b0, r1, c1);
    check64("R4", "register selected when use_imm=0", r1, 64'hA5A5_0F0F_3C3C_9999);

    // R5: sign classes
    apply(64'h0000_0000_0000_0001, 64'd63, 6'd0, 1'b0, 1'b0, r1, c1);
    check64("R5", "negative lt", {60'd0, c1}, 64'h8);
    apply(64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0, 1'b0, r1, c1);
    check64("R5", "positive gt", {60'd0, c1}, 64'h4);
    apply(64'd0, 64'd5, 6'd0, 1'b0, 1'b0, r1, c1);
    check64("R5", "zero eq", {60'd0, c1}, 64'h2);

    // R7: idle cycle drops out_valid
    @(negedge clk);
    check64("R7", "idle out_valid", {63'd0, out_valid}, 64'd0);

    // R2: random mix of modes, sources and amounts
    for (int n = 0; n < 400; n++) begin
      logic [63:0] s, ra;
      logic [5:0] im;
      s  = {$urandom, $urandom};
      ra = {$urandom, $urandom};
      im = 6'($urandom);
      run_checked("R2", s, ra, im, 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule